// File: doc/BRIEF.md
# Windowed Address Gate with Word Budget

This block paces the address channels of a memory-mapped bus. Time is split into repeating periods. Each period begins with an open phase of a configured number of cycles and ends with a closed phase of another configured number of cycles. Address handshakes can complete only while the phase is open. The block never touches the data channels.

Within each period the block also keeps a running total of the data words that admitted bursts will move. A read or write burst adds its length field plus one. Once that total is at or above a configured budget, no further address is admitted until the next period begins. The check is made before each transaction is admitted, not after, so a single burst admitted just below the budget may carry the total past it.

The gate drives one permit signal. Each address channel's ready is the downstream ready ANDed with that permit. The block is meant to emulate bandwidth limits when sweeping the performance of an accelerator's memory ports. Configuration is expected to hold steady while out of reset.

Top module: `bw_window_gate`

## Requirements
- R1: Reset clears both the phase counter and the word total. In the first cycle after reset, with an open length above zero, `permit` is 1.
- R2: For the first `cfg_on_len` cycles of each period, `permit` is 1 unless the budget is spent.
- R3: For the `cfg_off_len` cycles after the open phase, `permit` is 0, so no AR or AW handshake completes.
- R4: One period lasts `cfg_on_len + cfg_off_len` cycles. After that the next period starts again in the open phase.
- R5: Every completed AR or AW handshake (valid and ready both 1) adds its length field plus one to the word total. When AR and AW handshakes happen in the same cycle, both amounts are added in that cycle.
- R6: With `cfg_word_cap` nonzero and the word total at or above it, `permit` is 0 until the period ends. A burst admitted while the total is below the budget is counted in full, even if this carries the total past the budget.
- R7: With `cfg_word_cap` equal to 0 there is no budget, and the total never blocks.
- R8: The word total returns to zero when a new period starts. A handshake in the last cycle of a period is charged to that period, so it is dropped by the clear.
- R9: With `cfg_off_len` equal to 0 the phase is always open. The period is then `cfg_on_len` cycles (one cycle if that is also 0), and it sets when the budget clears.
- R10: `ar_ready` equals `ar_ready_src AND permit`, and `aw_ready` equals `aw_ready_src AND permit`.
- R11: With `cfg_on_len` equal to 0 and `cfg_off_len` nonzero, `permit` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_on_len | input | CNT_W | Open-phase length in cycles |
| cfg_off_len | input | CNT_W | Closed-phase length in cycles |
| cfg_word_cap | input | WORD_W | Word budget per period, 0 means unlimited |
| ar_valid | input | 1 | Read address valid |
| ar_ready_src | input | 1 | Read address ready from downstream |
| ar_len | input | LEN_W | Read burst length field (beats minus one) |
| aw_valid | input | 1 | Write address valid |
| aw_ready_src | input | 1 | Write address ready from downstream |
| aw_len | input | LEN_W | Write burst length field (beats minus one) |
| ar_ready | output | 1 | Gated read address ready |
| aw_ready | output | 1 | Gated write address ready |
| permit | output | 1 | Address admission allowed this cycle |

## Verification
The gate is driven with open/closed phases and no budget, which tests the phase timing apart from the word accounting. A tight budget with random burst lengths tests budget exhaustion apart from phase closure. Directed bursts cover three cases: a burst that starts below the budget and ends above it, simultaneous AR and AW handshakes landing exactly on the budget or one word short of it, and a phase that is always open or always closed. Randomised configurations then mix all of these. The bench's reference model is cycle-accurate, so a wrong period length, a missed clear or a lost second addend each shows up as a `permit` mismatch.

// File: rtl/bw_gate_pkg.sv
package bw_gate_pkg;

    // Why the address channels are, or are not, allowed through this cycle.
    typedef enum logic [1:0] {
        GATE_PASS   = 2'd0,
        GATE_CLOSED = 2'd1,
        GATE_SPENT  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/bw_phase_timer.sv
module bw_phase_timer #(
    parameter int CNT_W = 16,
    localparam int PH_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic [PH_W-1:0]  phase_q,
    output logic             open_o,
    output logic             last_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic [PH_W-1:0] period_len;

    always_comb begin
        st_d       = st_q;
        period_len = {1'b0, on_len} + {1'b0, off_len};
        // A zero-length period wraps every cycle; ">=" also recovers from an
        // out-of-range phase after a configuration change.
        last_o     = (period_len == '0) || (st_q.phase >= period_len - 1'b1);
        open_o     = (off_len == '0) || (st_q.phase < {1'b0, on_len});
        if (last_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q = st_q.phase;

endmodule

// File: rtl/bw_word_budget.sv
module bw_word_budget #(
    parameter int WORD_W = 20,
    parameter int LEN_W  = 8,
    localparam int SUM_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take_a,
    input  logic [LEN_W-1:0]  len_a,
    input  logic              take_b,
    input  logic [LEN_W-1:0]  len_b,
    input  logic [WORD_W-1:0] cap,
    output logic [WORD_W-1:0] words_q,
    output logic              spent_o
);

    typedef struct packed {
        logic [WORD_W-1:0] words;
    } budget_state_t;

    budget_state_t st_d, st_q;
    logic [SUM_W-1:0] inc_a, inc_b, total;

    always_comb begin
        st_d  = st_q;
        inc_a = take_a ? (SUM_W'(len_a) + SUM_W'(1)) : '0;
        inc_b = take_b ? (SUM_W'(len_b) + SUM_W'(1)) : '0;
        total = SUM_W'(st_q.words) + inc_a + inc_b;
        if (clear) begin
            st_d.words = '0;
        end else if (total[SUM_W-1:WORD_W] != '0) begin
            st_d.words = '1;
        end else begin
            st_d.words = total[WORD_W-1:0];
        end
        spent_o = (cap != '0) && (st_q.words >= cap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_q = st_q.words;

endmodule

// File: rtl/bw_window_gate.sv
module bw_window_gate
    import bw_gate_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 20,
    parameter int LEN_W  = 8,
    localparam int PH_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_on_len,
    input  logic [CNT_W-1:0]  cfg_off_len,
    input  logic [WORD_W-1:0] cfg_word_cap,
    input  logic              ar_valid,
    input  logic              ar_ready_src,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic              aw_valid,
    input  logic              aw_ready_src,
    input  logic [LEN_W-1:0]  aw_len,
    output logic              ar_ready,
    output logic              aw_ready,
    output logic              permit
);

    logic [PH_W-1:0]   phase_q;
    logic              phase_open;
    logic              period_last;
    logic [WORD_W-1:0] words_q;
    logic              budget_spent;
    logic              ar_take, aw_take;
    gate_state_e       gate_state;

    bw_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_len  (cfg_on_len),
        .off_len (cfg_off_len),
        .phase_q (phase_q),
        .open_o  (phase_open),
        .last_o  (period_last)
    );

    always_comb begin
        if (!phase_open) begin
            gate_state = GATE_CLOSED;
        end else if (budget_spent) begin
            gate_state = GATE_SPENT;
        end else begin
            gate_state = GATE_PASS;
        end
        permit   = (gate_state == GATE_PASS);
        ar_ready = ar_ready_src && permit;
        aw_ready = aw_ready_src && permit;
        ar_take  = ar_valid && ar_ready;
        aw_take  = aw_valid && aw_ready;
    end

    bw_word_budget #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (period_last),
        .take_a  (ar_take),
        .len_a   (ar_len),
        .take_b  (aw_take),
        .len_b   (aw_len),
        .cap     (cfg_word_cap),
        .words_q (words_q),
        .spent_o (budget_spent)
    );

endmodule

// File: rtl/bw_window_gate_chk.sv
module bw_window_gate_chk #(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 20,
    parameter int LEN_W  = 8,
    localparam int PH_W  = CNT_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_on_len,
    input logic [CNT_W-1:0]  cfg_off_len,
    input logic [WORD_W-1:0] cfg_word_cap,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [LEN_W-1:0]  ar_len,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [LEN_W-1:0]  aw_len,
    input logic              permit,
    input logic [PH_W-1:0]   phase_q,
    input logic              period_last,
    input logic [WORD_W-1:0] words_q
);

    logic              any_hs;
    logic [WORD_W-1:0] words_in;

    always_comb begin
        any_hs   = (ar_valid && ar_ready) || (aw_valid && aw_ready);
        words_in = ((ar_valid && ar_ready) ? (WORD_W'(ar_len) + WORD_W'(1)) : '0)
                 + ((aw_valid && aw_ready) ? (WORD_W'(aw_len) + WORD_W'(1)) : '0);
    end

    p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_off_len != '0 && phase_q >= {1'b0, cfg_on_len}) |-> !any_hs);

    p_spent_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word_cap != '0 && words_q >= cfg_word_cap) |-> !any_hs);

    p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_ready || aw_ready) |-> permit);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_last && !words_q[WORD_W-1] && !words_q[WORD_W-2])
        |=> words_q == $past(words_q) + $past(words_in));

    p_period_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_last |=> (words_q == '0) && (phase_q == '0));

    p_open_after_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_last && cfg_on_len != '0) |=> permit);

endmodule

bind bw_window_gate bw_window_gate_chk #(
    .CNT_W (CNT_W),
    .WORD_W(WORD_W),
    .LEN_W (LEN_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_on_len  (cfg_on_len),
    .cfg_off_len (cfg_off_len),
    .cfg_word_cap(cfg_word_cap),
    .ar_valid    (ar_valid),
    .ar_ready    (ar_ready),
    .ar_len      (ar_len),
    .aw_valid    (aw_valid),
    .aw_ready    (aw_ready),
    .aw_len      (aw_len),
    .permit      (permit),
    .phase_q     (phase_q),
    .period_last (period_last),
    .words_q     (words_q)
);

// File: tb/test_bw_window_gate.sv
module test_bw_window_gate;
    localparam int CNT_W  = 16;
    localparam int WORD_W = 20;
    localparam int LEN_W  = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [CNT_W-1:0]  cfg_on_len, cfg_off_len;
    logic [WORD_W-1:0] cfg_word_cap;
    logic ar_valid, ar_ready_src, aw_valid, aw_ready_src;
    logic [LEN_W-1:0] ar_len, aw_len;
    logic ar_ready, aw_ready, permit;

    bw_window_gate #(.CNT_W(CNT_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) i_bw_window_gate (
        .clk(clk), .rst_n(rst_n),
        .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len), .cfg_word_cap(cfg_word_cap),
        .ar_valid(ar_valid), .ar_ready_src(ar_ready_src), .ar_len(ar_len),
        .aw_valid(aw_valid), .aw_ready_src(aw_ready_src), .aw_len(aw_len),
        .ar_ready(ar_ready), .aw_ready(aw_ready), .permit(permit)
    );

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    int  on_i, off_i, cap_i;
    int  mph, mwords, mcycle;
    int  unsigned seed_sink;

    // Reference model derived from the requirements
    function automatic bit m_open();
        return (off_i == 0) || (mph < on_i);
    endfunction

    function automatic bit m_spent();
        return (cap_i != 0) && (mwords >= cap_i);
    endfunction

    function automatic bit m_last();
        int p = on_i + off_i;
        return (p == 0) || (mph >= p - 1);
    endfunction

    function automatic string m_tag();
        if (mcycle == 0)              return "R1";
        if (!m_open())                return (on_i == 0) ? "R11" : "R3";
        if (m_spent())                return "R6";
        if (mph == 0)                 return "R4 R8";
        if (off_i == 0)               return "R9";
        if (cap_i == 0)               return "R7";
        return "R2";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic apply_reset(int on, int off, int cap);
        @(negedge clk);
        rst_n = 1'b0;
        on_i = on; off_i = off; cap_i = cap;
        cfg_on_len   = CNT_W'(on);
        cfg_off_len  = CNT_W'(off);
        cfg_word_cap = WORD_W'(cap);
        ar_valid = 0; ar_ready_src = 0; ar_len = '0;
        aw_valid = 0; aw_ready_src = 0; aw_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mph = 0; mwords = 0; mcycle = 0;
    endtask

    // One cycle: drive at the falling edge, check, then advance the model at the rising edge.
    task automatic step(bit arv, bit arr, int arl, bit awv, bit awr, int awl);
        bit exp_p, hs_a, hs_w;
        ar_valid = arv; ar_ready_src = arr; ar_len = LEN_W'(arl);
        aw_valid = awv; aw_ready_src = awr; aw_len = LEN_W'(awl);
        #1;
        exp_p = m_open() && !m_spent();
        check(permit === exp_p, m_tag(), "permit", int'(permit), int'(exp_p));
        check(ar_ready === (arr && exp_p), "R10", "ar_ready", int'(ar_ready), int'(arr && exp_p));
        check(aw_ready === (awr && exp_p), "R10", "aw_ready", int'(aw_ready), int'(awr && exp_p));
        hs_a = arv && arr && exp_p;
        hs_w = awv && awr && exp_p;
        @(posedge clk);
        if (m_last()) begin
            mph = 0; mwords = 0;
        end else begin
            mph++;
            if (hs_a) mwords += arl + 1;
            if (hs_w) mwords += awl + 1;
            if (mwords > (1 << WORD_W) - 1) mwords = (1 << WORD_W) - 1;
        end
        mcycle++;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic random_run(int n, int lmax);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 3) != 0, ($urandom % 4) != 0, $urandom % (lmax + 1),
                 ($urandom % 3) != 0, ($urandom % 4) != 0, $urandom % (lmax + 1));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        seed_sink = $urandom(32'd1234);
        rst_n = 1'b0;

        // R1: state after reset, then R2/R3/R4/R7 with no budget
        apply_reset(10, 5, 0);
        #1;
        check(permit === 1'b1, "R1", "permit after reset", int'(permit), 1);
        random_run(60, 15);

        // R6: tight budget under random bursts
        apply_reset(20, 10, 12);
        random_run(100, 7);

        // R6: overshoot by a single burst admitted just under the budget
        apply_reset(50, 10, 10);
        step(1, 1, 7, 0, 0, 0);
        step(1, 1, 7, 0, 0, 0);
        #1;
        check(permit === 1'b0, "R6", "permit after overshoot", int'(permit), 0);
        step(1, 1, 3, 1, 1, 3);
        idle(70);

        // R5: AR and AW in the same cycle land exactly on the budget
        apply_reset(30, 5, 9);
        step(1, 1, 3, 1, 1, 4);
        #1;
        check(permit === 1'b0, "R5", "permit with both adds at budget", int'(permit), 0);
        idle(5);
        // R5: same pair one word under the budget keeps the gate open
        apply_reset(30, 5, 10);
        step(1, 1, 3, 1, 1, 4);
        #1;
        check(permit === 1'b1, "R5", "permit one word under budget", int'(permit), 1);
        step(1, 1, 0, 0, 0, 0);
        #1;
        check(permit === 1'b0, "R5", "permit after reaching budget", int'(permit), 0);
        idle(40);

        // R9: never closed, budget resets every on-length cycles
        apply_reset(8, 0, 6);
        random_run(60, 3);
        // R9: zero on and off lengths, one-cycle period
        apply_reset(0, 0, 4);
        random_run(30, 5);

        // R11: zero on length with a closed phase never admits
        apply_reset(0, 6, 0);
        random_run(30, 5);

        // R8: handshake in the final open cycle of a closed-less period is dropped
        apply_reset(4, 0, 5);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(1, 1, 7, 0, 0, 0);
        #1;
        check(permit === 1'b1, "R8", "permit after clear at period end", int'(permit), 1);
        idle(6);

        // Mixed random configurations
        for (int k = 0; k < 6; k++) begin
            apply_reset($urandom % 16, $urandom % 11, $urandom % 41);
            random_run(80, 15);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule